// File: doc/BRIEF.md
# Direct-Mapped Write-Through Byte Cache

This block sits between a byte-addressed processor port and a slower main memory that moves four-byte blocks. A 24-bit byte address is cut into three fields. The low two bits pick a byte inside a block. The next bits pick the single cache line that block may occupy. The remaining upper bits are kept as a tag, and a stored tag that matches on a valid line means a hit.

A read hit returns the byte straight from the line, with no memory traffic. A read miss stalls the processor while the whole block is fetched. The fetched block overwrites the indexed line and its tag. The byte is then served from the refreshed line.

Every processor write is sent to memory. The write also updates the cached byte when its block is resident, so the cache never holds anything newer than memory. A write that misses changes nothing in the cache.

Both ports use valid/ready handshakes. The processor keeps its request steady until the cycle in which ready is high. The cache keeps a memory request steady until memory raises ready. On a read, that ready cycle is also the cycle in which the block data is valid.

Top module: `dm_wt_cache`

## Requirements
- R1: With `LINES` lines, the address splits as follows: bits [1:0] are the byte, bits [IDX_W+1:2] are the line index (IDX_W = log2(LINES)), and the top 22−IDX_W bits are the tag. Blocks with equal index and different tag compete for one line. Blocks with different index never displace each other.
- R2: Reset clears every valid bit, so the first read of any block after reset is a miss.
- R3: A read hit raises `cpu_ready` in the same cycle the request is first presented. It returns the stored byte and issues no memory request.
- R4: A read miss issues exactly one memory read whose address is the block base (bits [1:0] zero). In the cycle after memory ready, `cpu_ready` rises with byte lane k of `mem_rdata`, meaning bits [8k+7:8k], where k is the address byte field.
- R5: A refill replaces the indexed line unconditionally, so a block evicted by a competing block misses on its next read.
- R6: Every processor write issues exactly one memory write carrying the full byte address and the data byte. `cpu_ready` is high exactly in the cycle memory accepts it.
- R7: A write that hits updates the cached byte. A later read of that byte hits and returns the new value.
- R8: A write that misses allocates nothing, so a later read of that block misses.
- R9: While a memory request waits for ready, `mem_req_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` on a read |
| mem_req_valid | output | 1 | Memory request present |
| mem_we | output | 1 | 1 = byte write, 0 = block read |
| mem_addr | output | 24 | Block base for reads, byte address for writes |
| mem_wdata | output | 8 | Byte to write |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 32 | Block read data, byte lane k at bits [8k+7:8k] |

## Verification
The assertions check the port protocol on every cycle. They cover the following:
- a waiting memory request is held steady (R9);
- a read completion never coincides with memory traffic (R3);
- a read request always targets a block base (R4);
- a completed write coincides with memory acceptance of the same address and byte (R6);
- a refill is followed by completion on the next cycle (R4).

Whether a given access should hit depends on history: what reset cleared, which block last claimed a line, and whether a write allocated. Only the bench's reference model of tags and memory contents can show this. It covers R1, R2, R5, R7 and R8, along with the correctness of returned bytes under random traffic and random memory latency.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } dmc_state_e;

    typedef struct packed {
        dmc_state_e state;
    } dmc_ctrl_s;

    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int BLOCK_W = BYTE_W * LANES;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 8,
    parameter int TAG_W  = ADDR_W - 2 - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        byte_sel,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    always_comb begin
        byte_sel = addr[1:0];
        idx      = addr[IDX_W+1:2];
        tag      = addr[ADDR_W-1:IDX_W+2];
    end
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store
    import dmc_pkg::*;
#(
    parameter int LINES = 256,
    parameter int IDX_W = $clog2(LINES),
    parameter int TAG_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx,
    output logic               line_valid,
    output logic [TAG_W-1:0]   line_tag,
    output logic [BLOCK_W-1:0] line_data,
    input  logic               fill_en,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [BLOCK_W-1:0] fill_data,
    input  logic               byte_en,
    input  logic [1:0]         byte_sel,
    input  logic [BYTE_W-1:0]  byte_val
);
    logic [LINES-1:0]   valid_d, valid_q;
    logic [TAG_W-1:0]   tag_q  [LINES];
    logic [BLOCK_W-1:0] data_q [LINES];
    logic [BLOCK_W-1:0] merged;

    // per-lane merge of a write byte into the indexed block
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            if (byte_sel == 2'(k))
                merged[k*BYTE_W +: BYTE_W] = byte_val;
            else
                merged[k*BYTE_W +: BYTE_W] = data_q[idx][k*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        valid_d = valid_q;
        if (fill_en)
            valid_d[idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else
            valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx]  <= fill_tag;
            data_q[idx] <= fill_data;
        end else if (byte_en) begin
            data_q[idx] <= merged;
        end
    end

    always_comb begin
        line_valid = valid_q[idx];
        line_tag   = tag_q[idx];
        line_data  = data_q[idx];
    end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_valid,
    input  logic cpu_we,
    input  logic hit,
    input  logic mem_ready,
    output logic cpu_ready,
    output logic mem_req_valid,
    output logic mem_we,
    output logic fill_en,
    output logic byte_en
);
    dmc_ctrl_s c_d, c_q;

    always_comb begin
        c_d           = c_q;
        cpu_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_we        = 1'b0;
        fill_en       = 1'b0;
        byte_en       = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (cpu_valid) begin
                    if (cpu_we)
                        c_d.state = ST_WRITE;
                    else if (hit)
                        cpu_ready = 1'b1;
                    else
                        c_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                if (mem_ready) begin
                    fill_en   = 1'b1;
                    c_d.state = ST_IDLE;
                end
            end
            ST_WRITE: begin
                mem_req_valid = 1'b1;
                mem_we        = 1'b1;
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    byte_en   = hit;
                    c_d.state = ST_IDLE;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            c_q.state <= ST_IDLE;
        else
            c_q <= c_d;
    end
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LINES  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ready,
    output logic [7:0]        cpu_rdata,
    output logic              mem_req_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - 2 - IDX_W;

    logic [1:0]         byte_sel;
    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tag;
    logic               line_valid;
    logic [TAG_W-1:0]   line_tag;
    logic [BLOCK_W-1:0] line_data;
    logic               hit, fill_en, byte_en;

    dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) split_i (
        .addr(cpu_addr), .byte_sel(byte_sel), .idx(idx), .tag(tag)
    );

    dmc_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .line_valid(line_valid), .line_tag(line_tag), .line_data(line_data),
        .fill_en(fill_en), .fill_tag(tag), .fill_data(mem_rdata),
        .byte_en(byte_en), .byte_sel(byte_sel), .byte_val(cpu_wdata)
    );

    assign hit = line_valid && (line_tag == tag);

    dmc_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .hit(hit), .mem_ready(mem_ready), .cpu_ready(cpu_ready),
        .mem_req_valid(mem_req_valid), .mem_we(mem_we),
        .fill_en(fill_en), .byte_en(byte_en)
    );

    assign cpu_rdata = line_data[{byte_sel, 3'b000} +: 8];
    assign mem_addr  = mem_we ? cpu_addr : {cpu_addr[ADDR_W-1:2], 2'b00};
    assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/dmc_chk.sv
module dmc_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_ready,
    input logic              mem_req_valid,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_ready
);
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_ready |=> mem_req_valid && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wdata));

    assert_read_done_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && !cpu_we |-> !mem_req_valid);

    assert_fill_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_we |-> mem_addr[1:0] == 2'b00);

    assert_fill_then_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid && !cpu_we && mem_req_valid && !mem_we && mem_ready |=> cpu_ready);

    assert_write_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && cpu_we |-> mem_req_valid && mem_we && mem_ready
            && mem_addr == cpu_addr && mem_wdata == cpu_wdata);
endmodule

bind dm_wt_cache dmc_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .mem_req_valid(mem_req_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/dm_wt_cache_tb_top.sv
module dm_wt_cache_tb_top;
    localparam int LINES = 16;
    localparam int IDX_W = 4;
    localparam int TAG_W = 24 - 2 - IDX_W;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_valid, cpu_we;
    logic [23:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        mem_req_valid, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ready;
    logic [31:0] mem_rdata;

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [23:0] last_rd_addr, last_wr_addr;
    logic [7:0]  last_wr_data;
    logic [7:0]  mem_m [int];
    logic             exp_valid [LINES];
    logic [TAG_W-1:0] exp_tag   [LINES];

    always #10 clk = ~clk;

    dm_wt_cache #(.ADDR_W(24), .LINES(LINES)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req_valid(mem_req_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_byte(logic [23:0] a);
        if (mem_m.exists(int'(a))) return mem_m[int'(a)];
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] mem_block(logic [23:0] a);
        logic [23:0] b = {a[23:2], 2'b00};
        return {mem_byte(b | 24'd3), mem_byte(b | 24'd2), mem_byte(b | 24'd1), mem_byte(b)};
    endfunction

    function automatic logic exp_hit(logic [23:0] a);
        return exp_valid[a[IDX_W+1:2]] && exp_tag[a[IDX_W+1:2]] == a[23:IDX_W+2];
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: random latency, data supplied with ready
    initial begin
        int dly = 1;
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
            end else if (mem_req_valid) begin
                if (dly == 0) begin
                    mem_ready = 1'b1;
                    mem_rdata = mem_block(mem_addr);
                    dly = $urandom_range(2, 0);
                end else begin
                    dly--;
                end
            end
        end
    end

    always @(posedge clk) begin
        if (mem_req_valid && mem_ready) begin
            if (mem_we) begin
                wr_cnt++;
                last_wr_addr = mem_addr;
                last_wr_data = mem_wdata;
                mem_m[int'(mem_addr)] = mem_wdata;
            end else begin
                rd_cnt++;
                last_rd_addr = mem_addr;
            end
        end
    end

    task automatic do_read(input logic [23:0] a, input string req);
        int waited = 0;
        int rd0 = rd_cnt;
        logic miss = !exp_hit(a);
        logic [7:0] expv = mem_byte(a);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_wdata = 8'h00;
        forever begin
            #1;
            if (cpu_ready || waited > 50) break;
            @(negedge clk);
            waited++;
        end
        chk(cpu_ready, {req, " completion"}, 32'(cpu_ready), 32'd1);
        chk(cpu_rdata == expv, {req, " data"}, 32'(cpu_rdata), 32'(expv));
        chk((rd_cnt - rd0) == (miss ? 1 : 0), {req, " mem reads"}, 32'(rd_cnt - rd0), miss ? 32'd1 : 32'd0);
        if (!miss)
            chk(waited == 0, {req, " hit latency R3"}, 32'(waited), 32'd0);
        else
            chk(last_rd_addr == {a[23:2], 2'b00}, {req, " fill address R4"}, 32'(last_rd_addr), 32'({a[23:2], 2'b00}));
        exp_valid[a[IDX_W+1:2]] = 1'b1;
        exp_tag[a[IDX_W+1:2]]   = a[23:IDX_W+2];
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic do_write(input logic [23:0] a, input logic [7:0] d, input string req);
        int waited = 0;
        int wr0 = wr_cnt;
        int rd0 = rd_cnt;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        forever begin
            #1;
            if (cpu_ready || waited > 50) break;
            @(negedge clk);
            waited++;
        end
        chk(cpu_ready, {req, " write completion R6"}, 32'(cpu_ready), 32'd1);
        @(negedge clk);
        cpu_valid = 1'b0;
        chk(wr_cnt - wr0 == 1 && rd_cnt == rd0, {req, " one mem write R6"}, 32'(wr_cnt - wr0), 32'd1);
        chk(last_wr_addr == a && last_wr_data == d, {req, " write addr/data R6"},
            {last_wr_addr, last_wr_data}, {a, d});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < LINES; i++) begin
            exp_valid[i] = 1'b0;
            exp_tag[i]   = '0;
        end
        rst_n = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!cpu_ready && !mem_req_valid, "reset idle R2", {cpu_ready, mem_req_valid}, 0);
        rst_n = 1'b1;

        // R2: cold read misses; R3: repeat hits; R4: other byte of same block hits
        do_read(24'h000010, "R2 cold read");
        do_read(24'h000010, "R3 repeat read");
        do_read(24'h000013, "R4 lane 3 of fetched block");
        // R1: neighbouring line is independent
        do_read(24'h000014, "R1 other line");
        do_read(24'h000011, "R1 first line still resident");
        // R5: same line, different tag evicts
        do_read(24'h000050, "R5 competing block");
        do_read(24'h000012, "R5 evicted block refetch");
        // R7: write hit updates cache
        do_write(24'h000012, 8'hA5, "R7 write hit");
        do_read(24'h000012, "R7 read after write hit");
        // R8: write miss does not allocate
        do_write(24'h123400, 8'h3C, "R8 write miss");
        do_read(24'h123400, "R8 read after write miss");
        do_read(24'h123400, "R8 second read");

        for (int n = 0; n < 300; n++) begin
            logic [23:0] a = {16'(($urandom_range(3, 0)) << 6) >> 6, 8'h00};
            a = {4'h0, 2'($urandom_range(3, 0)), 12'h000, 4'($urandom_range(15, 0)), 2'($urandom_range(3, 0))};
            if ($urandom_range(3, 0) == 0)
                do_write(a, 8'($urandom), "R6 random write");
            else
                do_read(a, "R1 random read");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule